// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a two-channel serial audio stream into parallel left and right sample words. It takes a bit clock, a frame clock that runs at the sample rate, and a serial data line. These three inputs are oversampled by the block's own system clock. A static two-bit format input selects one of four framings. Two are right-justified, with 16-bit or 18-bit words and a bit clock of 64 times the sample rate. The other two use a one-bit delay after each frame-clock transition: an 18-bit word on a 64fs bit clock, and a 16-bit word on a 32fs bit clock.

Each completed stereo frame is presented as two MSB-aligned words together with a single-cycle strobe. Bit slots that lie outside the data word are discarded. A new format value is taken at the start of a left half, and the frame that follows the switch is suppressed so that no sample decoded with mixed framing ever reaches the outputs.

Top module: `serial_audio_rx`

## Requirements
- R1: With format code 0, each half-frame has 32 bit slots and the word is the final 16 of them, MSB first. It is output in bits 17:2, and bits 1:0 are zero.
- R2: With format code 1, each half-frame has 32 slots and the 18-bit word is the final 18 of them, MSB first, output in bits 17:0.
- R3: With format code 2, each half-frame has 32 slots and the 18-bit word starts one slot after the frame-clock transition, MSB first. The rest of the half is unused.
- R4: With format code 3, each half-frame has 16 slots. The 16-bit word starts one slot after the transition, so its LSB falls in the first slot of the following half. It is output in bits 17:2, and bits 1:0 are zero.
- R5: Data and frame clock are sampled at rising bit-clock edges. A low frame clock marks the left channel and a high frame clock marks the right channel.
- R6: The values carried in slots outside the data word have no effect on the output words.
- R7: valid_o is high for exactly one clock after the right word of a frame completes. left_o and right_o change only in that cycle and otherwise hold their values.
- R8: Reset drives left_o and right_o to zero and valid_o low. The first frame after reset produces no strobe.
- R9: A change of fmt_i is adopted at the next left-half start. The frame in progress at the change is decoded with the old format, and the first frame sent in the new format is suppressed.
- R10: With no frame-clock transitions, no strobe is produced, whatever the bit clock and data do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial inputs |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Serial bit clock |
| lrck_i | input | 1 | Frame clock: low for left, high for right |
| sdat_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 2 | Framing select, codes 0 to 3 |
| left_o | output | SAMPLE_BITS | Left sample, MSB aligned |
| right_o | output | SAMPLE_BITS | Right sample, MSB aligned |
| valid_o | output | 1 | One-cycle strobe for each completed stereo frame |

## Verification
The hardest situation to reach is a format switch in the middle of a stream. This is most delicate when the switch moves between a framing without the one-slot delay and one with it, because the half boundary then moves by one bit. Another hard case is the 32fs framing, where the last bit of the right word arrives after the frame clock has already returned to left. The stimulus builds every frame slot by slot from the chosen format, placing the previous word's LSB in slot 0 of every half. It changes fmt_i partway through a left half, in both directions. The expected list then contains the old-format frame, leaves out the first new-format frame, and resumes with the frame after it.

// File: rtl/audrx_pkg.sv
`timescale 1ns/1ps
package audrx_pkg;
  typedef enum logic [1:0] {
    FMT_RJ16   = 2'd0,
    FMT_RJ18   = 2'd1,
    FMT_DLY18  = 2'd2,
    FMT_DLY16S = 2'd3
  } audrx_fmt_e;

  localparam int unsigned SAMPLE_W  = 18;
  localparam int unsigned SHORT_LEN = 16;
  localparam int unsigned LONG_LEN  = 18;

  // framings whose word starts one slot after the frame-clock edge
  function automatic logic fmt_delayed(audrx_fmt_e f);
    return (f == FMT_DLY18) || (f == FMT_DLY16S);
  endfunction

  function automatic logic fmt_short(audrx_fmt_e f);
    return (f == FMT_RJ16) || (f == FMT_DLY16S);
  endfunction
endpackage

// File: rtl/audrx_edge.sv
`timescale 1ns/1ps
module audrx_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_i,
  input  logic lrck_i,
  input  logic sdat_i,
  output logic rise_o,
  output logic lr_o,
  output logic sd_o
);
  // all three lines travel one shared pipeline so they stay aligned
  logic [2:0] pipe [STAGES];
  logic       bclk_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
      bclk_last <= 1'b0;
    end else begin
      pipe[0] <= {bclk_i, lrck_i, sdat_i};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      bclk_last <= pipe[STAGES-1][2];
    end
  end

  assign rise_o = pipe[STAGES-1][2] & ~bclk_last;
  assign lr_o   = pipe[STAGES-1][1];
  assign sd_o   = pipe[STAGES-1][0];
endmodule

// File: rtl/audrx_shift.sv
`timescale 1ns/1ps
module audrx_shift #(
  parameter int unsigned W = 18
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     step_i,
  input  logic                     restart_i,
  input  logic                     hold_after_i,
  input  logic [$clog2(W+1)-1:0]   len_i,
  input  logic                     din_i,
  output logic [W-1:0]             word_o
);
  localparam int unsigned CW = $clog2(W+1);

  logic [W-1:0]  sr;
  logic [CW-1:0] cnt;
  logic          full;

  assign full = (cnt >= len_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '0;
      cnt <= '0;
    end else if (step_i) begin
      if (restart_i) begin
        sr  <= {sr[W-2:0], din_i};
        cnt <= CW'(1);
      end else if (!(hold_after_i && full)) begin
        sr <= {sr[W-2:0], din_i};
        if (!full) cnt <= cnt + CW'(1);
      end
    end
  end

  // last len_i bits moved to the top, zero fill below
  assign word_o = sr << (W - len_i);
endmodule

// File: rtl/serial_audio_rx.sv
`timescale 1ns/1ps
module serial_audio_rx
  import audrx_pkg::*;
#(
  parameter int unsigned SAMPLE_BITS = SAMPLE_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bclk_i,
  input  logic                   lrck_i,
  input  logic                   sdat_i,
  input  logic [1:0]             fmt_i,
  output logic [SAMPLE_BITS-1:0] left_o,
  output logic [SAMPLE_BITS-1:0] right_o,
  output logic                   valid_o
);
  localparam int unsigned CW = $clog2(SAMPLE_BITS+1);

  logic                   bit_rise, lr_s, sd_s;
  audrx_fmt_e             act;
  logic                   lr1, eff_q, eff_now, frame_edge;
  logic                   started, left_ok, chg;
  logic [SAMPLE_BITS-1:0] word, left_hold;
  logic [CW-1:0]          len;

  audrx_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .bclk_i(bclk_i), .lrck_i(lrck_i), .sdat_i(sdat_i),
    .rise_o(bit_rise), .lr_o(lr_s), .sd_o(sd_s)
  );

  // delayed framings see the frame clock one slot late
  assign eff_now    = fmt_delayed(act) ? lr1 : lr_s;
  assign frame_edge = bit_rise && (eff_now != eff_q);
  assign len        = fmt_short(act) ? CW'(SHORT_LEN) : CW'(LONG_LEN);

  audrx_shift #(.W(SAMPLE_BITS)) u_shift (
    .clk(clk), .rst(rst), .step_i(bit_rise), .restart_i(frame_edge),
    .hold_after_i(fmt_delayed(act)), .len_i(len), .din_i(sd_s), .word_o(word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act       <= audrx_fmt_e'(fmt_i);
      lr1       <= 1'b0;
      eff_q     <= 1'b0;
      started   <= 1'b0;
      left_ok   <= 1'b0;
      chg       <= 1'b0;
      left_hold <= '0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (bit_rise) begin
        lr1   <= lr_s;
        eff_q <= eff_now;
      end
      if (frame_edge) begin
        started <= 1'b1;
        if (!eff_q) begin
          // left half just ended
          left_hold <= word;
          left_ok   <= started && !chg;
        end else begin
          // right half ended: publish the pair, then start a new frame
          if (left_ok) begin
            left_o  <= left_hold;
            right_o <= word;
            valid_o <= 1'b1;
          end
          left_ok <= 1'b0;
          if (audrx_fmt_e'(fmt_i) != act) begin
            act <= audrx_fmt_e'(fmt_i);
            chg <= 1'b1;
          end else begin
            chg <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx_chk.sv
`timescale 1ns/1ps
module serial_audio_rx_chk
  import audrx_pkg::*;
#(
  parameter int unsigned W = SAMPLE_W
) (
  input logic         clk,
  input logic         rst,
  input logic         valid_o,
  input logic [W-1:0] left_o,
  input logic [W-1:0] right_o,
  input logic         frame_edge,
  input audrx_fmt_e   act
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (rst)
    armed && valid_o |=> !valid_o);

  assert_outputs_hold_R7: assert property (@(posedge clk) disable iff (rst)
    armed && !valid_o |-> $stable(left_o) && $stable(right_o));

  // R1 and R4: short words leave the low bits empty
  assert_short_pad_R4: assert property (@(posedge clk) disable iff (rst)
    armed && valid_o && fmt_short($past(act)) |->
      left_o[W-SHORT_LEN-1:0] == '0 && right_o[W-SHORT_LEN-1:0] == '0);

  assert_strobe_needs_edge_R10: assert property (@(posedge clk) disable iff (rst)
    armed && valid_o |-> $past(frame_edge));

  assert_format_at_edge_R9: assert property (@(posedge clk) disable iff (rst)
    armed && !$stable(act) |-> $past(frame_edge));

  assert_reset_state_R8: assert property (@(posedge clk)
    rst |=> !valid_o && left_o == '0 && right_o == '0);
endmodule

bind serial_audio_rx serial_audio_rx_chk #(.W(SAMPLE_BITS)) u_chk (
  .clk(clk), .rst(rst), .valid_o(valid_o), .left_o(left_o), .right_o(right_o),
  .frame_edge(frame_edge), .act(act)
);

// File: tb/serial_audio_rx_tb.sv
`timescale 1ns/1ps
module serial_audio_rx_tb;
  localparam int W = 18;

  logic clk = 1'b0, rst = 1'b1, bclk = 1'b0, lrck = 1'b0, sdat = 1'b0;
  logic [1:0] fmt = 2'd0;
  logic [W-1:0] left_o, right_o;
  logic valid_o;

  always #4 clk = ~clk;

  serial_audio_rx u_dut (
    .clk(clk), .rst(rst), .bclk_i(bclk), .lrck_i(lrck), .sdat_i(sdat),
    .fmt_i(fmt), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  int checks = 0, errors = 0;
  int n_exp = 0, n_got = 0;
  logic [W-1:0] exp_l [256];
  logic [W-1:0] exp_r [256];
  string exp_tag [256];
  int junk_mode = 0;
  logic prev_lsb = 1'b0;
  bit done = 0;

  always @(negedge clk) begin
    if (!rst && valid_o) begin
      checks++;
      if (n_got >= n_exp) begin
        errors++;
        $display("FAIL R7: extra strobe, got L=%h R=%h expected none", left_o, right_o);
      end else if (left_o !== exp_l[n_got] || right_o !== exp_r[n_got]) begin
        errors++;
        $display("FAIL %s/R5: frame %0d got L=%h R=%h expected L=%h R=%h",
                 exp_tag[n_got], n_got, left_o, right_o, exp_l[n_got], exp_r[n_got]);
      end
      n_got++;
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic logic [W-1:0] expect_word(int mode, logic [17:0] w);
    return (mode == 0 || mode == 3) ? {w[15:0], 2'b00} : w;
  endfunction

  function automatic logic junk();
    if (junk_mode == 1) return 1'b0;
    if (junk_mode == 2) return 1'b1;
    return 1'($urandom % 2);
  endfunction

  function automatic logic [17:0] pat(int f, int ch);
    case (f)
      1: return ch ? 18'h20000 : 18'h1FFFF;
      2: return ch ? 18'h3FFFF : 18'h00001;
      3: return ch ? 18'h2AAAA : 18'h15555;
      4: return ch ? 18'h08000 : 18'h00002;
      default: return 18'($urandom);
    endcase
  endfunction

  task automatic slot(logic lr, logic d);
    @(negedge clk);
    bclk = 1'b0; lrck = lr; sdat = d;
    repeat (2) @(negedge clk);
    bclk = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_frame(int mode, logic [17:0] l, logic [17:0] r, int sw);
    int n = (mode == 0 || mode == 3) ? 16 : 18;
    int slots = (mode == 3) ? 16 : 32;
    for (int h = 0; h < 2; h++) begin
      logic [17:0] w;
      w = h ? r : l;
      for (int s = 0; s < slots; s++) begin
        logic b;
        if (h == 0 && s == 3 && sw >= 0) fmt = 2'(sw);
        if (s == 0) b = prev_lsb;
        else if (mode < 2) b = (s >= slots - n) ? w[n - 1 - (s - (slots - n))] : junk();
        else b = (s - 1 < n) ? w[n - s] : junk();
        slot(h[0], b);
      end
      prev_lsb = w[0];
    end
  endtask

  task automatic push(int mode, logic [17:0] l, logic [17:0] r, string tag);
    exp_l[n_exp] = expect_word(mode, l);
    exp_r[n_exp] = expect_word(mode, r);
    exp_tag[n_exp] = tag;
    n_exp++;
  endtask

  task automatic do_reset(int mode);
    fmt = 2'(mode); rst = 1'b1; bclk = 1'b0; lrck = 1'b0; prev_lsb = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 reset valid", 64'(valid_o), 64'd0);
    check("R8 reset left", 64'(left_o), 64'd0);
    check("R8 reset right", 64'(right_o), 64'd0);
    n_exp = 0; n_got = 0;
    rst = 1'b0;
  endtask

  task automatic run_mode(int mode, string tag, int nf);
    do_reset(mode);
    for (int f = 0; f <= nf; f++) begin
      logic [17:0] l, r;
      l = pat(f, 0); r = pat(f, 1);
      if (f >= 1 && f < nf) push(mode, l, r, tag);
      send_frame(mode, l, r, -1);
    end
    repeat (20) @(negedge clk);
    check("R8 frames delivered (first dropped)", 64'(n_got), 64'(nf - 1));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, got %0d expected completion", n_got);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    run_mode(0, "R1", 8);
    run_mode(1, "R2", 8);
    run_mode(2, "R3", 8);
    run_mode(3, "R4", 8);
    junk_mode = 2;
    for (int m = 0; m < 4; m++) run_mode(m, "R6", 5);
    junk_mode = 1;
    for (int m = 0; m < 4; m++) run_mode(m, "R6", 5);
    junk_mode = 0;

    // R9: switch 0 -> 2 during frame 3, then 2 -> 1 during frame 7
    do_reset(0);
    for (int f = 0; f <= 10; f++) begin
      int mode, sw;
      logic [17:0] l, r;
      mode = (f <= 3) ? 0 : (f <= 7) ? 2 : 1;
      sw = (f == 3) ? 2 : (f == 7) ? 1 : -1;
      l = pat(f, 0); r = pat(f, 1);
      if (f != 0 && f != 4 && f != 8 && f != 10) push(mode, l, r, "R9");
      send_frame(mode, l, r, sw);
    end
    repeat (20) @(negedge clk);
    check("R9 frames delivered across switches", 64'(n_got), 64'd7);

    // R10: bit clock and data toggle, frame clock stuck low
    do_reset(1);
    for (int s = 0; s < 300; s++) slot(1'b0, 1'($urandom % 2));
    repeat (20) @(negedge clk);
    check("R10 no strobe without frame clock", 64'(n_got), 64'd0);
    check("R10 left unchanged", 64'(left_o), 64'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule